// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block expands one prefixed scalar operation into a run of per-element operations. A setvl-style command loads a vector length register, clamped to the number of register-file entries. A start pulse then latches two predicate masks, one for the source side and one for the destination side, together with a walk direction. Each mask is taken from an integer bit vector, from one chosen bit of every 4-bit condition field (plain or inverted), or is treated as all ones.

Once started, the sequencer presents one source/destination index pair per cycle with a valid strobe. The source pointer and the destination pointer each jump to their own next enabled element, so the two sides are predicated independently. The forward walk counts up from element 0. The reverse walk counts down toward element 0. When either side runs out of enabled elements below the vector length, a single-cycle `done` closes the sequence. Register-file access and the arithmetic belong to the surrounding pipeline.

Top module: `vec_elem_seq`

## Requirements
- R1: A `setvl` pulse loads the vector length register with min(`vl_req`, MAXVL). Reset sets the vector length to 0. A `start` in the same cycle as `setvl` uses the old length.
- R2: Every issued index lies in 0..vl-1 of the length in force at start. Indices are clog2(MAXVL) bits wide.
- R3: Source mask mode `src_mode`: 2'b00 enables all elements, 2'b01 enables element i when `src_int[i]` is 1, 2'b10 enables element i when bit `src_sel` of condition field i (`cr_fields[4*i+3:4*i]`) is 1, and 2'b11 enables element i when that bit is 0.
- R4: The destination mask uses the same encoding through `dst_mode`, `dst_int` and `dst_sel`, and is resolved independently of the source mask.
- R5: In forward order (`reverse`=0), the k-th issued pair holds the k-th lowest enabled source element and the k-th lowest enabled destination element. If `start` is high in cycle c, pairs appear in consecutive cycles c+2, c+3, and so on.
- R6: In reverse order (`reverse`=1), the k-th pair holds the k-th highest enabled source element and the k-th highest enabled destination element below vl, with the same timing.
- R7: After min(source count, destination count) pairs, `done` is high for exactly one cycle, in the cycle after the last pair. It is never high together with `el_valid`.
- R8: When vl is 0, or either effective mask has no enabled element below vl, no pair is issued and `done` is high in cycle c+1.
- R9: Mask, direction and length are captured at start. A `start` or `setvl` during a running sequence does not alter that sequence.
- R10: After reset, `el_valid` and `done` are low until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setvl | input | 1 | Load vector length command |
| vl_req | input | VLW | Requested vector length |
| start | input | 1 | Launch a sequence |
| reverse | input | 1 | Walk from highest element down |
| src_mode | input | 2 | Source mask mode |
| src_int | input | MAXVL | Source integer mask bits |
| src_sel | input | 2 | Bit chosen inside each condition field for the source |
| dst_mode | input | 2 | Destination mask mode |
| dst_int | input | MAXVL | Destination integer mask bits |
| dst_sel | input | 2 | Bit chosen inside each condition field for the destination |
| cr_fields | input | 4*MAXVL | Condition fields, field i in bits 4i+3..4i |
| el_valid | output | 1 | Index pair valid strobe |
| el_src | output | IDX_W | Source element index |
| el_dst | output | IDX_W | Destination element index |
| done | output | 1 | Sequence finished, one cycle |

## Verification
The hardest situation to reach is a new `start` or `setvl` that arrives while a sequence is running. The bench raises both in the middle of a run, with different masks and a different length, and expects the pair stream to stay the same. Enabled mask bits that lie beyond the vector length are also hard to reach. The sweep covers them by pairing every 8-bit source mask with lengths 0 through 9, in both directions and in all destination mask modes.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int CRF_W = 4;
  localparam int SEL_W = $clog2(CRF_W);

  typedef enum logic [1:0] {
    PM_ALL = 2'b00,
    PM_INT = 2'b01,
    PM_CR  = 2'b10,
    PM_CRN = 2'b11
  } pm_mode_t;

  function automatic logic pm_pick(pm_mode_t mode, logic int_bit, logic cr_bit);
    case (mode)
      PM_ALL:  pm_pick = 1'b1;
      PM_INT:  pm_pick = int_bit;
      PM_CR:   pm_pick = cr_bit;
      default: pm_pick = ~cr_bit;
    endcase
  endfunction
endpackage

// File: rtl/vseq_mask_resolve.sv
module vseq_mask_resolve
  import vseq_pkg::*;
#(
  parameter int MAXVL = 128,
  parameter int VLW   = 8
) (
  input  pm_mode_t                   mode,
  input  logic [MAXVL-1:0]           int_bits,
  input  logic [CRF_W*MAXVL-1:0]     cr_bits,
  input  logic [SEL_W-1:0]           cr_sel,
  input  logic [VLW-1:0]             vl,
  output logic [MAXVL-1:0]           mask
);
  for (genvar gi = 0; gi < MAXVL; gi++) begin : g_elem
    logic [CRF_W-1:0] field;
    logic             in_range;
    assign field    = cr_bits[CRF_W*gi +: CRF_W];
    assign in_range = VLW'(gi) < vl;
    assign mask[gi] = in_range & pm_pick(mode, int_bits[gi], field[cr_sel]);
  end
endmodule

// File: rtl/vseq_elem_scan.sv
module vseq_elem_scan #(
  parameter int MAXVL = 128,
  parameter int IDX_W = 7
) (
  input  logic [MAXVL-1:0] mask,
  input  logic             rev,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |mask;
    idx   = '0;
    if (!rev) begin
      for (int i = MAXVL - 1; i >= 0; i--) begin
        if (mask[i]) idx = IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < MAXVL; i++) begin
        if (mask[i]) idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int MAXVL = 128,
  localparam int IDX_W = $clog2(MAXVL),
  localparam int VLW   = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   setvl,
  input  logic [VLW-1:0]         vl_req,
  input  logic                   start,
  input  logic                   reverse,
  input  logic [1:0]             src_mode,
  input  logic [MAXVL-1:0]       src_int,
  input  logic [1:0]             src_sel,
  input  logic [1:0]             dst_mode,
  input  logic [MAXVL-1:0]       dst_int,
  input  logic [1:0]             dst_sel,
  input  logic [4*MAXVL-1:0]     cr_fields,
  output logic                   el_valid,
  output logic [IDX_W-1:0]       el_src,
  output logic [IDX_W-1:0]       el_dst,
  output logic                   done
);
  localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

  logic [VLW-1:0]   vl_q;
  logic             busy_q;
  logic             rev_q;
  logic [MAXVL-1:0] src_rem, dst_rem;
  logic [MAXVL-1:0] src_res, dst_res;
  logic             src_found, dst_found;
  logic [IDX_W-1:0] src_idx, dst_idx;

  vseq_mask_resolve #(.MAXVL(MAXVL), .VLW(VLW)) u_src_res (
    .mode(pm_mode_t'(src_mode)), .int_bits(src_int), .cr_bits(cr_fields),
    .cr_sel(src_sel), .vl(vl_q), .mask(src_res)
  );

  vseq_mask_resolve #(.MAXVL(MAXVL), .VLW(VLW)) u_dst_res (
    .mode(pm_mode_t'(dst_mode)), .int_bits(dst_int), .cr_bits(cr_fields),
    .cr_sel(dst_sel), .vl(vl_q), .mask(dst_res)
  );

  vseq_elem_scan #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_src_scan (
    .mask(src_rem), .rev(rev_q), .found(src_found), .idx(src_idx)
  );

  vseq_elem_scan #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_dst_scan (
    .mask(dst_rem), .rev(rev_q), .found(dst_found), .idx(dst_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q     <= '0;
      busy_q   <= 1'b0;
      rev_q    <= 1'b0;
      src_rem  <= '0;
      dst_rem  <= '0;
      el_valid <= 1'b0;
      el_src   <= '0;
      el_dst   <= '0;
      done     <= 1'b0;
    end else begin
      el_valid <= 1'b0;
      done     <= 1'b0;
      if (setvl) vl_q <= (vl_req > VL_MAX) ? VL_MAX : vl_req;
      if (!busy_q) begin
        if (start) begin
          if ((|src_res) && (|dst_res)) begin
            busy_q  <= 1'b1;
            rev_q   <= reverse;
            src_rem <= src_res;
            dst_rem <= dst_res;
          end else begin
            done <= 1'b1;
          end
        end
      end else if (src_found && dst_found) begin
        el_valid         <= 1'b1;
        el_src           <= src_idx;
        el_dst           <= dst_idx;
        src_rem[src_idx] <= 1'b0;
        dst_rem[dst_idx] <= 1'b0;
      end else begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  // R7: done lasts one cycle and never coincides with a pair
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && el_valid));
  // R2: an issued element is removed from both pending sets
  a_r2_issued_retired: assert property (@(posedge clk) disable iff (rst)
    el_valid |-> (!src_rem[el_src] && !dst_rem[el_dst] && busy_q));
  // R5: forward walk strictly ascends
  a_r5_fwd_ascend: assert property (@(posedge clk) disable iff (rst)
    (el_valid && $past(el_valid) && !rev_q) |->
      (el_src > $past(el_src) && el_dst > $past(el_dst)));
  // R6: reverse walk strictly descends
  a_r6_rev_descend: assert property (@(posedge clk) disable iff (rst)
    (el_valid && $past(el_valid) && rev_q) |->
      (el_src < $past(el_src) && el_dst < $past(el_dst)));
  // R8: zero length finishes at once with no pair
  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q && vl_q == '0) |=> (done && !el_valid));
  // R1: length never exceeds the register-file size
  a_r1_vl_clamp: assert property (@(posedge clk) disable iff (rst)
    vl_q <= VL_MAX);
endmodule

// File: tb/vec_elem_seq_tb.sv
`timescale 1ns/1ps
module vec_elem_seq_tb;
  localparam int M   = 8;
  localparam int IW  = $clog2(M);
  localparam int VW  = IW + 1;

  logic clk = 0, rst = 1;
  logic setvl = 0, start = 0, reverse = 0;
  logic [VW-1:0] vl_req = '0;
  logic [1:0] src_mode = 0, dst_mode = 0, src_sel = 0, dst_sel = 0;
  logic [M-1:0] src_int = '0, dst_int = '0;
  logic [4*M-1:0] cr_fields = '0;
  logic el_valid, done;
  logic [IW-1:0] el_src, el_dst;

  int checks = 0, errors = 0, exp_vl = 0;
  int es[M], ed[M];

  always #2 clk = ~clk;

  vec_elem_seq #(.MAXVL(M)) u_dut (
    .clk(clk), .rst(rst), .setvl(setvl), .vl_req(vl_req), .start(start),
    .reverse(reverse), .src_mode(src_mode), .src_int(src_int), .src_sel(src_sel),
    .dst_mode(dst_mode), .dst_int(dst_int), .dst_sel(dst_sel),
    .cr_fields(cr_fields), .el_valid(el_valid), .el_src(el_src),
    .el_dst(el_dst), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit effbit(logic [1:0] md, logic [M-1:0] iv,
                                logic [4*M-1:0] cr, logic [1:0] sel, int i);
    case (md)
      2'b00: return 1'b1;
      2'b01: return iv[i];
      2'b10: return cr[4*i + int'(sel)];
      default: return !cr[4*i + int'(sel)];
    endcase
  endfunction

  task automatic do_setvl(input int req);
    @(negedge clk);
    setvl = 1; vl_req = VW'(req);
    @(negedge clk);
    setvl = 0;
    exp_vl = (req > M) ? M : req;
  endtask

  task automatic run(input bit inject, input string tagv);
    int ns = 0, nd = 0, n, run_vl, last;
    run_vl = exp_vl;
    for (int k = 0; k < run_vl; k++) begin
      int i = reverse ? run_vl - 1 - k : k;
      if (effbit(src_mode, src_int, cr_fields, src_sel, i)) begin es[ns] = i; ns++; end
      if (effbit(dst_mode, dst_int, cr_fields, dst_sel, i)) begin ed[nd] = i; nd++; end
    end
    n = (ns < nd) ? ns : nd;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    last = (n == 0) ? 1 : n + 2;
    for (int j = 0; j <= last; j++) begin
      bit ev = (n > 0) && (j >= 1) && (j <= n);
      bit ed_ = (n == 0) ? (j == 0) : (j == n + 1);
      chk(tagv, int'(el_valid), int'(ev));
      chk((n == 0) ? "R8 done" : "R7 done", int'(done), int'(ed_));
      if (ev && el_valid) begin
        chk(tagv, int'(el_src), es[j-1]);
        chk(tagv, int'(el_dst), ed[j-1]);
        chk("R2 range", int'(el_src < run_vl && el_dst < run_vl), 1);
      end
      if (inject && j == 1) begin
        start = 1; setvl = 1; vl_req = VW'(3);
        src_int = ~src_int; dst_mode = 2'b00; reverse = ~reverse;
      end
      if (inject && j == 2) begin
        start = 0; setvl = 0; exp_vl = 3;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 valid", int'(el_valid), 0);
    chk("R10 done", int'(done), 0);
    // R8: reset length is zero, all-ones masks still issue nothing
    run(0, "R8 empty");
    // R1: oversize request clamps to M
    do_setvl(13);
    src_mode = 2'b00; dst_mode = 2'b00; reverse = 0;
    run(0, "R1 clamp");
    // R3 and R4: condition-field modes, including inverted
    cr_fields = 32'h5A3C_96E1;
    for (int sm = 0; sm < 4; sm++)
      for (int dm = 0; dm < 4; dm++)
        for (int sl = 0; sl < 4; sl++) begin
          src_mode = 2'(sm); dst_mode = 2'(dm); src_sel = 2'(sl); dst_sel = 2'(3 - sl);
          src_int = 8'hB6; dst_int = 8'h6D;
          run(0, "R3 R4 modes");
        end
    // R9: start and setvl during a run are ignored by that run
    do_setvl(8);
    src_mode = 2'b01; dst_mode = 2'b01; src_int = 8'hF3; dst_int = 8'hDE; reverse = 0;
    run(1, "R9 busy start");
    // R5 R6 R8: sweep length, direction and source mask
    for (int vr = 0; vr <= 9; vr++) begin
      do_setvl(vr);
      for (int rv = 0; rv < 2; rv++)
        for (int s = 0; s < 256; s++) begin
          reverse = rv[0];
          src_mode = 2'b01; src_int = 8'(s);
          dst_mode = 2'(s); dst_sel = 2'(s >> 2);
          dst_int = 8'(s * 37 + vr) ^ 8'hA5;
          cr_fields = 32'(s * 32'h9E37_79B1) ^ 32'(vr);
          run(0, rv ? "R6 reverse" : "R5 forward");
        end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule